// File: doc/BRIEF.md
# FM Synthesizer Dual Interval Timer

This block holds the two interval timers of an FM sound generator. Timer A is a 10-bit up-counter. Timer B is an 8-bit up-counter that advances once for every 16 sample ticks. Each timer counts toward its full-scale value. On the tick after it reaches full scale it wraps: it reloads a programmed start value and can raise a status flag. Software programs the start values and a control byte through a byte-wide write port. It reads back a status byte that holds the two overflow flags and a busy bit. The busy bit stays high for a fixed window after every write.

Timer A also drives a composite-sine mode for channel 3. While the control byte selects that mode, each wrap of timer A sends a key-on strobe to all four operators of the channel. The next count step of timer A sends the matching key-off strobe. The tone generator consumes both strobes. The block contains no tone or audio logic.

The block is clocked by the system clock. It advances only on cycles where `smp_tick` is high, so one tick is one sample period. Control and status pins are plain level or pulse signals. The block has no streaming interface, and so no back-pressure rules apply.

Top module: `fm_timer_pair`

## Requirements
- R1: After reset `status` reads 0x00, `key_on` and `key_off` are zero, both counters sit at full scale, and the load values and control byte are cleared.
- R2: The control byte is written at address 0x13. Bit 0 enables timer A, bit 1 enables timer B, bit 2 enables the A flag, bit 3 enables the B flag, bits 5:4 are write-one-to-clear bits for the B and A flags, and bits 7:6 are the mode field. An enabled timer A adds one per tick. On the tick after it reaches 1023 it reloads its 10-bit load value. Address 0x10 supplies load bits 9:2 from data 7:0, and address 0x11 supplies load bits 1:0 from data 1:0.
- R3: A 0-to-1 change of a timer's enable bit forces that counter to full scale. The first wrap after that reloads the counter but raises no flag.
- R4: Any later wrap sets status bit 0 (timer A) or status bit 1 (timer B), but only when that timer's flag-enable bit is 1.
- R5: A control write with bit 4 set clears flag A, and one with bit 5 set clears flag B. A clear wins over a flag set in the same cycle.
- R6: Writing a load value does not change a running count. The new value takes effect at the next reload.
- R7: Timer B (8 bits, load value at address 0x12) advances only on ticks where a 16-tick prescaler is at phase zero. The prescaler runs freely from reset.
- R8: If timer B is waiting for its first reload and a tick arrives at a non-zero prescaler phase, the counter loads its load value at once and the wait ends, so no later flag is suppressed.
- R9: While the mode field is binary 10, each wrap of timer A pulses `key_on` to 4'hF for one cycle, provided no composite key-on is already active. In other modes `key_on` stays zero.
- R10: The first timer A count step after a composite key-on pulses `key_off` to 4'hF for one cycle.
- R11: A control write that moves the mode field away from 10 while the composite key-on is active pulses `key_off` to 4'hF in the cycle after the write.
- R12: Status bit 7 goes high at the first tick after any write and stays high for 32 ticks. Status bits 6:2 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_tick | input | 1 | One-cycle sample-period tick that advances timers, prescaler and busy window |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Register write data |
| status | output | 8 | Bit 7 busy, bit 1 flag B, bit 0 flag A |
| key_on | output | 4 | One-cycle composite key-on strobe, one bit per operator |
| key_off | output | 4 | One-cycle composite key-off strobe, one bit per operator |

## Verification
The bench builds the block with its default parameters: 10-bit and 8-bit timers, a prescale of 16, a 32-tick busy window and four key lines. It loads start values within a few counts of full scale. This puts a second timer A wrap only a handful of ticks after enabling, and a second timer B wrap within two prescaler periods. The bench tracks the free-running prescaler phase by counting its own ticks. This lets it place a timer B enable at a known non-zero phase and predict the immediate load and the flag tick exactly.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  localparam logic [1:0] MODE_COMPOSITE = 2'b10;

  typedef struct packed {
    logic [1:0] mode;
    logic       ovf_b;
    logic       ovf_a;
    logic       en_b;
    logic       en_a;
  } ctrl_t;
endpackage

// File: rtl/fmt_regs.sv
module fmt_regs
  import fmt_pkg::*;
#(
  parameter int          TA_W      = 10,
  parameter int          TB_W      = 8,
  parameter logic [7:0]  ADDR_A_HI = 8'h10,
  parameter logic [7:0]  ADDR_A_LO = 8'h11,
  parameter logic [7:0]  ADDR_B    = 8'h12,
  parameter logic [7:0]  ADDR_CTRL = 8'h13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_addr,
  input  logic [7:0]      wr_data,
  output logic [TA_W-1:0] load_a,
  output logic [TB_W-1:0] load_b,
  output ctrl_t           ctrl,
  output logic            restart_a,
  output logic            restart_b,
  output logic            clr_a,
  output logic            clr_b,
  output logic            mode_exit
);
  localparam int HI_W = TA_W - 2;

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

  // strobes derived from the incoming byte against the stored control
  assign restart_a = ctrl_wr && wr_data[0] && !ctrl.en_a;
  assign restart_b = ctrl_wr && wr_data[1] && !ctrl.en_b;
  assign clr_a     = ctrl_wr && wr_data[4];
  assign clr_b     = ctrl_wr && wr_data[5];
  assign mode_exit = ctrl_wr && (ctrl.mode == MODE_COMPOSITE)
                     && (wr_data[7:6] != MODE_COMPOSITE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_a <= '0;
      load_b <= '0;
      ctrl   <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_A_HI) load_a[TA_W-1:2] <= wr_data[HI_W-1:0];
      if (wr_addr == ADDR_A_LO) load_a[1:0]      <= wr_data[1:0];
      if (wr_addr == ADDR_B)    load_b           <= wr_data[TB_W-1:0];
      if (ctrl_wr) begin
        ctrl.mode  <= wr_data[7:6];
        ctrl.ovf_b <= wr_data[3];
        ctrl.ovf_a <= wr_data[2];
        ctrl.en_b  <= wr_data[1];
        ctrl.en_a  <= wr_data[0];
      end
    end
  end

  assert_restart_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart_a |=> ctrl.en_a);
endmodule

// File: rtl/fmt_counter.sv
module fmt_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         step,
  input  logic         idle_load,
  input  logic [W-1:0] load_val,
  output logic         wrap,
  output logic         wrap_first,
  output logic         incr
);
  localparam logic [W-1:0] FULL = '1;

  logic [W-1:0] cnt;
  logic         pend;
  logic         at_full;

  assign at_full    = (cnt == FULL);
  assign wrap       = step && !restart && at_full;
  assign wrap_first = wrap && pend;
  assign incr       = step && !restart && !at_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= FULL;
      pend <= 1'b0;
    end else if (restart) begin
      cnt  <= FULL;
      pend <= 1'b1;
    end else if (step) begin
      if (at_full) begin
        cnt  <= load_val;
        pend <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (idle_load && pend) begin
      cnt  <= load_val;
      pend <= 1'b0;
    end
  end

  assert_wrap_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart && at_full) |=> (cnt == $past(load_val)));
  assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart && !at_full) |=> (cnt == $past(cnt) + 1'b1));
  assert_restart_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (at_full && pend));
  assert_idle_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_load && pend && !restart && !step) |=> (!pend && cnt == $past(load_val)));
endmodule

// File: rtl/fmt_prescale.sv
module fmt_prescale #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic at_zero
);
  localparam int PW = $clog2(DIV);
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;
  assign at_zero = (phase == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)           phase <= '0;
    else if (tick) begin
      if (phase == LAST)  phase <= '0;
      else                phase <= phase + 1'b1;
    end
  end

  assert_phase_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && phase == LAST) |=> at_zero);
endmodule

// File: rtl/fmt_busy.sv
module fmt_busy #(
  parameter int WINDOW = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_any,
  input  logic tick,
  output logic busy
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] START = CW'(WINDOW);

  logic          armed;
  logic [CW-1:0] left;

  assign busy = (left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      left  <= '0;
    end else begin
      if (wr_any)     armed <= 1'b1;
      else if (tick)  armed <= 1'b0;
      if (tick && armed)           left <= START;
      else if (tick && left != '0) left <= left - 1'b1;
    end
  end

  assert_busy_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tick));
  assert_busy_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && busy) |=> busy);
endmodule

// File: rtl/fm_timer_pair.sv
module fm_timer_pair
  import fmt_pkg::*;
#(
  parameter int          TA_W      = 10,
  parameter int          TB_W      = 8,
  parameter int          TB_DIV    = 16,
  parameter int          BUSY_LEN  = 32,
  parameter int          KEY_OPS   = 4,
  parameter logic [7:0]  ADDR_A_HI = 8'h10,
  parameter logic [7:0]  ADDR_A_LO = 8'h11,
  parameter logic [7:0]  ADDR_B    = 8'h12,
  parameter logic [7:0]  ADDR_CTRL = 8'h13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_tick,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr,
  input  logic [7:0]         wr_data,
  output logic [7:0]         status,
  output logic [KEY_OPS-1:0] key_on,
  output logic [KEY_OPS-1:0] key_off
);
  logic [TA_W-1:0] load_a;
  logic [TB_W-1:0] load_b;
  ctrl_t           ctrl;
  logic restart_a, restart_b, clr_a, clr_b, mode_exit;
  logic wrap_a, first_a, incr_a;
  logic wrap_b, first_b, incr_b;
  logic b_phase0, busy;
  logic flag_a, flag_b, comp_active;
  logic fire_on, fire_off;

  fmt_regs #(
    .TA_W(TA_W), .TB_W(TB_W), .ADDR_A_HI(ADDR_A_HI), .ADDR_A_LO(ADDR_A_LO),
    .ADDR_B(ADDR_B), .ADDR_CTRL(ADDR_CTRL)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_a(load_a), .load_b(load_b), .ctrl(ctrl), .restart_a(restart_a),
    .restart_b(restart_b), .clr_a(clr_a), .clr_b(clr_b), .mode_exit(mode_exit)
  );

  fmt_counter #(.W(TA_W)) u_tmr_a (
    .clk(clk), .rst_n(rst_n), .restart(restart_a), .step(smp_tick && ctrl.en_a),
    .idle_load(1'b0), .load_val(load_a), .wrap(wrap_a), .wrap_first(first_a),
    .incr(incr_a)
  );

  fmt_prescale #(.DIV(TB_DIV)) u_pre_b (
    .clk(clk), .rst_n(rst_n), .tick(smp_tick), .at_zero(b_phase0)
  );

  fmt_counter #(.W(TB_W)) u_tmr_b (
    .clk(clk), .rst_n(rst_n), .restart(restart_b),
    .step(smp_tick && b_phase0 && ctrl.en_b), .idle_load(smp_tick && !b_phase0),
    .load_val(load_b), .wrap(wrap_b), .wrap_first(first_b), .incr(incr_b)
  );

  fmt_busy #(.WINDOW(BUSY_LEN)) u_busy (
    .clk(clk), .rst_n(rst_n), .wr_any(wr_en), .tick(smp_tick), .busy(busy)
  );

  // composite-sine key strobes
  assign fire_on  = wrap_a && !comp_active && (ctrl.mode == MODE_COMPOSITE);
  assign fire_off = comp_active && (incr_a || mode_exit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_a      <= 1'b0;
      flag_b      <= 1'b0;
      comp_active <= 1'b0;
      key_on      <= '0;
      key_off     <= '0;
    end else begin
      if (clr_a)                                  flag_a <= 1'b0;
      else if (wrap_a && !first_a && ctrl.ovf_a)  flag_a <= 1'b1;
      if (clr_b)                                  flag_b <= 1'b0;
      else if (wrap_b && !first_b && ctrl.ovf_b)  flag_b <= 1'b1;
      if (fire_off)      comp_active <= 1'b0;
      else if (fire_on)  comp_active <= 1'b1;
      key_on  <= {KEY_OPS{fire_on}};
      key_off <= {KEY_OPS{fire_off}};
    end
  end

  assign status = {busy, 5'b0, flag_b, flag_a};

  assert_flag_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_a) |-> ($past(ctrl.ovf_a) && $past(wrap_a) && !$past(first_a)));
  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_b |=> !flag_b);
  assert_keys_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !((|key_on) && (|key_off)));
  assert_exit_keyoff_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_exit && comp_active) |=> (key_off == {KEY_OPS{1'b1}}));
  assert_b_idle_unused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    incr_b |-> b_phase0);
endmodule

// File: tb/fm_timer_pair_tb.sv
`timescale 1ns/1ps
module fm_timer_pair_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] status;
  logic [3:0] key_on, key_off;

  int checks = 0;
  int errors = 0;
  int tb_ticks = 0;
  int on_cnt = 0;
  int off_cnt = 0;
  bit done = 0;

  localparam logic [7:0] A_HI = 8'h10, A_LO = 8'h11, B_LD = 8'h12, CTRL = 8'h13;

  always #4 clk = ~clk;

  fm_timer_pair u_dut (
    .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .status(status),
    .key_on(key_on), .key_off(key_off)
  );

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      smp_tick = 1'b1;
      @(posedge clk); @(negedge clk);
      smp_tick = 1'b0;
      tb_ticks++;
      if (key_on == 4'hF) on_cnt++;
      else if (key_on != 4'h0) check(int'(key_on), 15, "R9 strobe width");
      if (key_off == 4'hF) off_cnt++;
      else if (key_off != 4'h0) check(int'(key_off), 15, "R10 strobe width");
    end
  endtask

  task automatic t_reset();
    check(int'(status), 0, "R1 status");
    check(int'(key_on), 0, "R1 key_on");
    check(int'(key_off), 0, "R1 key_off");
  endtask

  task automatic t_timer_a_flag();
    wr(A_HI, 8'hFF); wr(A_LO, 8'h00);     // load 1020
    wr(CTRL, 8'h05);
    run_ticks(4);
    check(int'(status[1:0]), 0, "R3 first wrap no flag");
    run_ticks(1);
    check(int'(status[1:0]), 1, "R2 second wrap flag A");
  endtask

  task automatic t_clear_and_gate();
    wr(CTRL, 8'h15);
    check(int'(status[1:0]), 0, "R5 clear flag A");
    wr(CTRL, 8'h11);
    run_ticks(8);
    check(int'(status[1:0]), 0, "R4 flag gated off");
  endtask

  task automatic t_load_timing();
    wr(CTRL, 8'h30);
    wr(CTRL, 8'h05);
    run_ticks(1);                          // first wrap -> 1020
    wr(A_LO, 8'h03);                       // load 1023, count untouched
    run_ticks(3);
    check(int'(status[0]), 0, "R6 running count kept");
    run_ticks(1);
    check(int'(status[0]), 1, "R6 wrap at old schedule");
    wr(CTRL, 8'h15);
    run_ticks(1);
    check(int'(status[0]), 1, "R6 new load used after reload");
  endtask

  task automatic t_timer_b();
    wr(CTRL, 8'h30);
    wr(B_LD, 8'd254);
    while ((tb_ticks % 16) != 1) run_ticks(1);
    wr(CTRL, 8'h0A);
    run_ticks(31);
    check(int'(status[1:0]), 0, "R8 R7 before B flag");
    run_ticks(1);
    check(int'(status[1:0]), 2, "R7 prescaled B flag");
  endtask

  task automatic t_composite();
    wr(CTRL, 8'h30);
    wr(A_HI, 8'hFF); wr(A_LO, 8'h02);     // load 1022
    on_cnt = 0; off_cnt = 0;
    wr(CTRL, 8'h81);
    run_ticks(1);
    check(on_cnt, 1, "R9 key-on at wrap");
    run_ticks(1);
    check(off_cnt, 1, "R10 key-off at increment");
    run_ticks(1);
    check(on_cnt, 2, "R9 key-on at next wrap");
    wr(CTRL, 8'h01);
    check(int'(key_off), 15, "R11 key-off on mode exit");
    wr(CTRL, 8'h41);
    on_cnt = 0; off_cnt = 0;
    run_ticks(10);
    check(on_cnt, 0, "R9 no key-on outside mode");
    check(off_cnt, 0, "R10 no key-off outside mode");
  endtask

  task automatic t_busy();
    wr(CTRL, 8'h30);
    run_ticks(40);
    check(int'(status[7]), 0, "R12 idle");
    wr(B_LD, 8'h00);
    check(int'(status[7]), 0, "R12 not before tick");
    run_ticks(1);
    check(int'(status[7]), 1, "R12 rises at first tick");
    run_ticks(31);
    check(int'(status[7]), 1, "R12 high at tick 32");
    run_ticks(1);
    check(int'(status[7]), 0, "R12 low at tick 33");
    check(int'(status[6:2]), 0, "R12 unused bits");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timer_a_flag();
    t_clear_and_gate();
    t_load_timing();
    t_timer_b();
    t_composite();
    t_busy();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule